// File: doc/BRIEF.md
# Register Operand Staging Store

This block is a small banked, tagged store that holds register values only for warps that are currently running. It replaces a full-size register file. An allocation controller claims a line for each register that a warp's next region will touch, before that warp may issue. Registers that arrive from the next memory level are loaded through a fill port. Registers that are produced and consumed inside the region get a line but are never fetched. The execution pipeline then reads and writes those lines, and because space was set aside in advance, no access by an active warp ever misses.

When a region ends, the controller releases each register with a keep hint. A kept register that holds a value stays resident as a cached line, and a later region can claim it without any fetch. A dropped register is erased at once and never written back. If a bank has no free line when a claim arrives, a resident cached line is taken over and its contents leave through the eviction port toward the compressor and memory.

Each tag is a warp number plus a register number. The bank is selected by the low bits of the register number. With the default parameters the store has 4 banks of 128 lines each, 512 lines in total.

Top module: `opnd_stage`

## Requirements
- R1: After reset every line is free. A read of any register flags `miss_err`, and `ev_valid` is low.
- R2: A claim for a register not resident goes to the lowest-numbered free line of bank `reg[BW-1:0]` (bits [1:0] by default), and `rsv_grant` is high. A read of that line before it is written flags `miss_err`.
- R3: A fill to a claimed line stores the value, which both read ports return from the next cycle with `miss_err` low. Read data is combinational from stored state.
- R4: A pipeline writeback to a claimed line needs no prior fill, and a later writeback replaces the earlier value.
- R5: A release with `rel_keep`=1 of a written line keeps it cached. A read of it then flags `miss_err`. A new claim of the same tag hits it, keeps the data and produces no eviction.
- R6: A release with `rel_keep`=0, or of a line never written, frees the line without any eviction output. A later claim of that tag gets an unwritten line.
- R7: When a bank has no free line and no cached line, a claim returns `rsv_grant`=0 and changes nothing.
- R8: When a bank has no free line, a claim takes the lowest-numbered cached line of that bank. One cycle later `ev_valid` pulses with that line's warp, register and data, and the old tag is no longer resident. A free line is always used in preference to a cached one.
- R9: A fill, writeback or release whose tag has no claimed line flags `miss_err` and changes no state.
- R10: Banks are independent: a full bank does not affect claims in another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsv_valid | input | 1 | Claim a line for a register |
| rsv_warp | input | WW | Warp of the claim |
| rsv_reg | input | RW | Register number of the claim |
| rsv_grant | output | 1 | Claim accepted this cycle |
| fill_valid | input | 1 | Preloaded value arrives |
| fill_warp | input | WW | Warp of the fill |
| fill_reg | input | RW | Register of the fill |
| fill_data | input | DW | Fill value |
| wb_valid | input | 1 | Pipeline writeback |
| wb_warp | input | WW | Warp of the writeback |
| wb_reg | input | RW | Register of the writeback |
| wb_data | input | DW | Writeback value |
| rd0_en | input | 1 | Read port 0 enable |
| rd0_warp | input | WW | Read port 0 warp |
| rd0_reg | input | RW | Read port 0 register |
| rd0_data | output | DW | Read port 0 value (zero on miss) |
| rd1_en | input | 1 | Read port 1 enable |
| rd1_warp | input | WW | Read port 1 warp |
| rd1_reg | input | RW | Read port 1 register |
| rd1_data | output | DW | Read port 1 value (zero on miss) |
| rel_valid | input | 1 | End-of-region release of a register |
| rel_warp | input | WW | Warp of the release |
| rel_reg | input | RW | Register of the release |
| rel_keep | input | 1 | 1 keeps the line cached, 0 drops it |
| ev_valid | output | 1 | Evicted line is presented |
| ev_warp | output | WW | Warp of the evicted line |
| ev_reg | output | RW | Register of the evicted line |
| ev_data | output | DW | Data of the evicted line |
| miss_err | output | 1 | An access found no claimed line |

## Verification
The assertions check four things on every cycle. An eviction pulse only follows a granted claim. A grant never appears without a request. The eviction output is quiet after reset and after a release. A read of an unchanged address with no intervening update returns stable data. Only the bench scenarios can show the following: the order in which lines are chosen, keep versus drop at region end, victim selection in a full bank, the full-bank refusal, and the data carried out on eviction. All of these need knowledge of which tags were placed earlier.

// File: rtl/opnd_stage.sv
module opnd_stage #(
  parameter int NW    = 32,
  parameter int NR    = 64,
  parameter int NBANK = 4,
  parameter int LPB   = 128,
  parameter int DW    = 32,
  localparam int WW   = $clog2(NW),
  localparam int RW   = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rsv_valid,
  input  logic [WW-1:0] rsv_warp,
  input  logic [RW-1:0] rsv_reg,
  output logic          rsv_grant,
  input  logic          fill_valid,
  input  logic [WW-1:0] fill_warp,
  input  logic [RW-1:0] fill_reg,
  input  logic [DW-1:0] fill_data,
  input  logic          wb_valid,
  input  logic [WW-1:0] wb_warp,
  input  logic [RW-1:0] wb_reg,
  input  logic [DW-1:0] wb_data,
  input  logic          rd0_en,
  input  logic [WW-1:0] rd0_warp,
  input  logic [RW-1:0] rd0_reg,
  output logic [DW-1:0] rd0_data,
  input  logic          rd1_en,
  input  logic [WW-1:0] rd1_warp,
  input  logic [RW-1:0] rd1_reg,
  output logic [DW-1:0] rd1_data,
  input  logic          rel_valid,
  input  logic [WW-1:0] rel_warp,
  input  logic [RW-1:0] rel_reg,
  input  logic          rel_keep,
  output logic          ev_valid,
  output logic [WW-1:0] ev_warp,
  output logic [RW-1:0] ev_reg,
  output logic [DW-1:0] ev_data,
  output logic          miss_err
);
  localparam int BW = $clog2(NBANK);
  localparam int LW = $clog2(LPB);
  localparam int IW = BW + LW;
  localparam int NL = NBANK * LPB;

  logic [NL-1:0] vld, rsv;
  logic [WW-1:0] tw  [NL];
  logic [RW-1:0] tr  [NL];
  logic [DW-1:0] mem [NL];

  function automatic logic [IW:0] find(input logic [WW-1:0] w, input logic [RW-1:0] r,
                                       input logic need_r, input logic need_v);
    logic [IW:0] res;
    res = '0;
    for (int l = LPB - 1; l >= 0; l--) begin
      logic [IW-1:0] i;
      i = {r[BW-1:0], LW'(l)};
      if ((vld[i] | rsv[i]) && (!need_r || rsv[i]) && (!need_v || vld[i]) &&
          tw[i] == w && tr[i] == r)
        res = {1'b1, i};
    end
    return res;
  endfunction

  function automatic logic [IW:0] pick(input logic [BW-1:0] b, input logic cached);
    logic [IW:0] res;
    res = '0;
    for (int l = LPB - 1; l >= 0; l--) begin
      logic [IW-1:0] i;
      i = {b, LW'(l)};
      if (!rsv[i] && (vld[i] == cached)) res = {1'b1, i};
    end
    return res;
  endfunction

  logic          rh, fh, vh, flh, wh, lh, r0h, r1h;
  logic [IW-1:0] ri, fi, vi, fli, wi, li, r0i, r1i;

  assign {rh, ri}   = find(rsv_warp, rsv_reg, 1'b0, 1'b0);
  assign {fh, fi}   = pick(rsv_reg[BW-1:0], 1'b0);
  assign {vh, vi}   = pick(rsv_reg[BW-1:0], 1'b1);
  assign {flh, fli} = find(fill_warp, fill_reg, 1'b1, 1'b0);
  assign {wh, wi}   = find(wb_warp, wb_reg, 1'b1, 1'b0);
  assign {lh, li}   = find(rel_warp, rel_reg, 1'b1, 1'b0);
  assign {r0h, r0i} = find(rd0_warp, rd0_reg, 1'b1, 1'b1);
  assign {r1h, r1i} = find(rd1_warp, rd1_reg, 1'b1, 1'b1);

  logic          alloc, victim;
  logic [IW-1:0] ai;

  assign alloc     = rsv_valid && !rh && (fh || vh);
  assign victim    = alloc && !fh;
  assign ai        = fh ? fi : vi;
  assign rsv_grant = rsv_valid && (rh || fh || vh);
  assign rd0_data  = r0h ? mem[r0i] : '0;
  assign rd1_data  = r1h ? mem[r1i] : '0;
  assign miss_err  = (fill_valid && !flh) || (wb_valid && !wh) || (rel_valid && !lh) ||
                     (rd0_en && !r0h) || (rd1_en && !r1h);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld      <= '0;
      rsv      <= '0;
      ev_valid <= 1'b0;
    end else begin
      ev_valid <= victim;
      if (rsv_valid && rh) rsv[ri] <= 1'b1;
      if (alloc) begin
        rsv[ai] <= 1'b1;
        vld[ai] <= 1'b0;
      end
      if (fill_valid && flh) vld[fli] <= 1'b1;
      if (wb_valid && wh) vld[wi] <= 1'b1;
      if (rel_valid && lh) begin
        rsv[li] <= 1'b0;
        if (!(rel_keep && vld[li])) vld[li] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      tw[ai] <= rsv_warp;
      tr[ai] <= rsv_reg;
    end
    if (victim) begin
      ev_warp <= tw[vi];
      ev_reg  <= tr[vi];
      ev_data <= mem[vi];
    end
    if (fill_valid && flh) mem[fli] <= fill_data;
    if (wb_valid && wh) mem[wi] <= wb_data;
  end
endmodule

// File: rtl/opnd_stage_chk.sv
module opnd_stage_chk #(
  parameter int WW = 5,
  parameter int RW = 6,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rsv_valid,
  input logic          rsv_grant,
  input logic          fill_valid,
  input logic          wb_valid,
  input logic          rel_valid,
  input logic          rd0_en,
  input logic [WW-1:0] rd0_warp,
  input logic [RW-1:0] rd0_reg,
  input logic [DW-1:0] rd0_data,
  input logic          ev_valid
);
  p_ev_after_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ($past(rsv_valid) && $past(rsv_grant)));

  p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_grant |-> rsv_valid);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !ev_valid);

  p_drop_no_ev_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !rsv_valid) |=> !ev_valid);

  p_read_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_en && $past(rd0_en) && rd0_warp == $past(rd0_warp) && rd0_reg == $past(rd0_reg) &&
     !$past(fill_valid || wb_valid || rel_valid || rsv_valid)) |-> $stable(rd0_data));
endmodule

bind opnd_stage opnd_stage_chk #(.WW(WW), .RW(RW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rsv_valid(rsv_valid), .rsv_grant(rsv_grant),
  .fill_valid(fill_valid), .wb_valid(wb_valid), .rel_valid(rel_valid),
  .rd0_en(rd0_en), .rd0_warp(rd0_warp), .rd0_reg(rd0_reg), .rd0_data(rd0_data),
  .ev_valid(ev_valid)
);

// File: tb/test_opnd_stage.sv
module test_opnd_stage;
  localparam int CLK_PERIOD = 10;
  localparam int WW = 5, RW = 6, DW = 32, LPB = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rsv_valid = 0, fill_valid = 0, wb_valid = 0, rd0_en = 0, rd1_en = 0, rel_valid = 0, rel_keep = 0;
  logic [WW-1:0] rsv_warp = '0, fill_warp = '0, wb_warp = '0, rd0_warp = '0, rd1_warp = '0, rel_warp = '0;
  logic [RW-1:0] rsv_reg = '0, fill_reg = '0, wb_reg = '0, rd0_reg = '0, rd1_reg = '0, rel_reg = '0;
  logic [DW-1:0] fill_data = '0, wb_data = '0;
  logic rsv_grant, ev_valid, miss_err;
  logic [DW-1:0] rd0_data, rd1_data, ev_data;
  logic [WW-1:0] ev_warp;
  logic [RW-1:0] ev_reg;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  opnd_stage i_opnd_stage (
    .clk(clk), .rst_n(rst_n),
    .rsv_valid(rsv_valid), .rsv_warp(rsv_warp), .rsv_reg(rsv_reg), .rsv_grant(rsv_grant),
    .fill_valid(fill_valid), .fill_warp(fill_warp), .fill_reg(fill_reg), .fill_data(fill_data),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg), .wb_data(wb_data),
    .rd0_en(rd0_en), .rd0_warp(rd0_warp), .rd0_reg(rd0_reg), .rd0_data(rd0_data),
    .rd1_en(rd1_en), .rd1_warp(rd1_warp), .rd1_reg(rd1_reg), .rd1_data(rd1_data),
    .rel_valid(rel_valid), .rel_warp(rel_warp), .rel_reg(rel_reg), .rel_keep(rel_keep),
    .ev_valid(ev_valid), .ev_warp(ev_warp), .ev_reg(ev_reg), .ev_data(ev_data),
    .miss_err(miss_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op_rsv(input int w, input int r, output logic g);
    rsv_valid = 1; rsv_warp = WW'(w); rsv_reg = RW'(r);
    #1 g = rsv_grant;
    @(negedge clk);
    rsv_valid = 0;
  endtask

  task automatic op_wr(input bit is_wb, input int w, input int r, input logic [DW-1:0] d, output logic e);
    if (is_wb) begin wb_valid = 1; wb_warp = WW'(w); wb_reg = RW'(r); wb_data = d; end
    else begin fill_valid = 1; fill_warp = WW'(w); fill_reg = RW'(r); fill_data = d; end
    #1 e = miss_err;
    @(negedge clk);
    wb_valid = 0; fill_valid = 0;
  endtask

  task automatic op_rel(input int w, input int r, input bit keep, output logic e);
    rel_valid = 1; rel_warp = WW'(w); rel_reg = RW'(r); rel_keep = keep;
    #1 e = miss_err;
    @(negedge clk);
    rel_valid = 0;
  endtask

  task automatic op_rd(input bit port, input int w, input int r, output logic [DW-1:0] d, output logic e);
    if (port) begin rd1_en = 1; rd1_warp = WW'(w); rd1_reg = RW'(r); end
    else begin rd0_en = 1; rd0_warp = WW'(w); rd0_reg = RW'(r); end
    #1 e = miss_err; d = port ? rd1_data : rd0_data;
    rd0_en = 0; rd1_en = 0;
    #1;
  endtask

  task automatic t_reset;
    logic [DW-1:0] d; logic e;
    chk(ev_valid == 0, "R1 ev_valid", 64'(ev_valid), 0);
    op_rd(0, 3, 5, d, e);
    chk(e == 1, "R1 read miss", 64'(e), 1);
    chk(d == 0, "R1 read data", 64'(d), 0);
  endtask

  task automatic t_fill;
    logic [DW-1:0] d; logic e, g;
    op_rsv(3, 5, g);
    chk(g == 1, "R2 grant", 64'(g), 1);
    op_rd(0, 3, 5, d, e);
    chk(e == 1, "R2 unwritten read", 64'(e), 1);
    op_wr(0, 3, 5, 32'hA5A5_0001, e);
    chk(e == 0, "R3 fill hit", 64'(e), 0);
    op_rd(0, 3, 5, d, e);
    chk(e == 0 && d == 32'hA5A5_0001, "R3 read port0", 64'(d), 64'hA5A5_0001);
    op_rd(1, 3, 5, d, e);
    chk(e == 0 && d == 32'hA5A5_0001, "R3 read port1", 64'(d), 64'hA5A5_0001);
  endtask

  task automatic t_interior;
    logic [DW-1:0] d; logic e, g;
    op_rsv(4, 6, g);
    chk(g == 1, "R4 grant", 64'(g), 1);
    op_wr(1, 4, 6, 32'h1234, e);
    chk(e == 0, "R4 wb hit", 64'(e), 0);
    op_rd(0, 4, 6, d, e);
    chk(e == 0 && d == 32'h1234, "R4 read", 64'(d), 64'h1234);
    op_wr(1, 4, 6, 32'h5678, e);
    op_rd(1, 4, 6, d, e);
    chk(e == 0 && d == 32'h5678, "R4 overwrite", 64'(d), 64'h5678);
  endtask

  task automatic t_keep;
    logic [DW-1:0] d; logic e, g;
    op_rel(3, 5, 1, e);
    chk(e == 0, "R5 release hit", 64'(e), 0);
    op_rd(0, 3, 5, d, e);
    chk(e == 1, "R5 cached not readable", 64'(e), 1);
    op_rsv(3, 5, g);
    chk(g == 1 && ev_valid == 0, "R5 reclaim no evict", {62'(0), g, ev_valid}, 64'h2);
    op_rd(0, 3, 5, d, e);
    chk(e == 0 && d == 32'hA5A5_0001, "R5 data kept", 64'(d), 64'hA5A5_0001);
  endtask

  task automatic t_drop;
    logic [DW-1:0] d; logic e, g;
    op_rel(4, 6, 0, e);
    chk(ev_valid == 0, "R6 drop no evict", 64'(ev_valid), 0);
    op_rsv(4, 6, g);
    op_rd(0, 4, 6, d, e);
    chk(e == 1, "R6 dropped value gone", 64'(e), 1);
    op_rel(4, 6, 1, e);
    op_rsv(4, 6, g);
    op_rd(0, 4, 6, d, e);
    chk(e == 1, "R6 unwritten keep frees", 64'(e), 1);
    op_rel(4, 6, 0, e);
    op_rel(3, 5, 0, e);
  endtask

  task automatic t_errs;
    logic e;
    op_wr(0, 7, 9, 32'h1, e);
    chk(e == 1, "R9 fill miss", 64'(e), 1);
    op_wr(1, 7, 9, 32'h1, e);
    chk(e == 1, "R9 wb miss", 64'(e), 1);
    op_rel(7, 9, 1, e);
    chk(e == 1, "R9 release miss", 64'(e), 1);
  endtask

  task automatic t_full;
    logic [DW-1:0] d; logic e, g;
    int bad = 0;
    for (int j = 0; j < LPB; j++) begin
      op_rsv(j >> 4, (j & 15) << 2, g);
      if (!g) bad++;
    end
    chk(bad == 0, "R2 fill bank grants", 64'(bad), 0);
    op_wr(1, 0, 20, 32'h105, e);
    op_wr(1, 0, 36, 32'h109, e);
    op_rel(0, 20, 1, e);
    op_rel(0, 36, 1, e);
    op_rel(1, 16, 0, e);
    op_rsv(9, 0, g);
    chk(g == 1 && ev_valid == 0, "R8 free line preferred", {62'(0), g, ev_valid}, 64'h2);
    op_rsv(9, 4, g);
    chk(g == 1 && ev_valid == 1, "R8 victim evicted", {62'(0), g, ev_valid}, 64'h3);
    chk(ev_warp == 0 && ev_reg == 20 && ev_data == 32'h105, "R8 evict content",
        {ev_warp, ev_reg, ev_data}, {5'd0, 6'd20, 32'h105});
    op_rd(0, 0, 20, d, e);
    chk(e == 1, "R8 old tag gone", 64'(e), 1);
    op_rsv(9, 8, g);
    chk(ev_valid == 1 && ev_reg == 36 && ev_data == 32'h109, "R8 second victim",
        {ev_reg, ev_data}, {6'd36, 32'h109});
    op_rsv(9, 12, g);
    chk(g == 0 && ev_valid == 0, "R7 full refuse", {62'(0), g, ev_valid}, 64'h0);
    op_rd(0, 9, 12, d, e);
    chk(e == 1, "R7 nothing placed", 64'(e), 1);
    op_rsv(0, 1, g);
    chk(g == 1, "R10 other bank grant", 64'(g), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_interior();
    t_keep();
    t_drop();
    t_errs();
    t_full();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule